// File: doc/BRIEF.md
# Serial-In Parallel-Out Register Driver

This block takes one byte at a time from an internal client and loads it into an external serial-in, parallel-out register that has an output latch. Four lines connect it to that register: a serial data line, a shift strobe, a latch strobe and an active-low output enable. The client waits for `ready`, then pulses `start` for one cycle with the byte on `data_in`. The driver stores the byte and sends it on the data line, most significant bit first. It raises the shift strobe once per bit and then raises the latch strobe once, so that all eight external outputs change together.

Both strobes are paced by a phase timer. Each high phase and each low phase lasts `PHASE_CLKS` system clocks. A data bit is placed on the line for a full low phase before its shift strobe rises, and it does not change until that strobe has fallen. With the default settings a transfer holds `ready` low for 90 system clocks. The register's clear input is not driven. The output enable follows the `drive_en` input one clock later.

Top module: `serial_latch_driver`

## Requirements
- R1: Reset drives `ready` high, `shift_clk` and `latch_clk` low, and `out_en_n` low.
- R2: A `start` pulse sampled while `ready` is high is accepted. `ready` is low in the next cycle.
- R3: A `start` pulse sampled while `ready` is low is ignored. The byte in flight, the strobe counts and the transfer length are unchanged.
- R4: Bits go out most significant first. After the transfer, external output bit i equals `data_in` bit i as captured at acceptance, for i = 0..7.
- R5: Each transfer produces exactly `DATA_W` (8) shift-strobe rising edges and then exactly one latch-strobe pulse.
- R6: `ser_data` is stable for at least one system clock before each shift-strobe rising edge. It stays stable for the whole high phase.
- R7: Every high phase of `shift_clk` and `latch_clk` lasts exactly `PHASE_CLKS` system clocks.
- R8: `ready` stays low for exactly (2*`DATA_W`+2)*`PHASE_CLKS` system clocks per transfer, which is 90 with the defaults.
- R9: `out_en_n` equals the inverse of `drive_en` as sampled at the previous clock edge. A low level enables the external outputs.
- R10: `shift_clk` and `latch_clk` are never high together. Both are low whenever `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to send `data_in` |
| data_in | input | DATA_W | Byte to send |
| drive_en | input | 1 | High to enable the external outputs |
| ready | output | 1 | High while idle and able to accept a byte |
| ser_data | output | 1 | Serial data to the external register |
| shift_clk | output | 1 | Shift strobe; its rising edge shifts in `ser_data` |
| latch_clk | output | 1 | Latch strobe; its rising edge copies the shift stage to the outputs |
| out_en_n | output | 1 | Active-low output enable |

## Verification
A wrong bit counter or a wrong shift direction shows up as soon as the latch strobe fires. The external register model then holds a wrong or mirrored byte, or it has counted a number of shift edges other than eight. A phase timer that is off by one changes the width of a strobe pulse within a single phase, and it also changes the busy length of the whole transfer. A sequencer that wrongly accepts a new request while busy is exposed in the same transfer: a request is injected mid-transfer, and the latched byte, the edge counts and the busy length are all checked.

// File: rtl/sld_pkg.sv
package sld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT_L = 3'd1,
    ST_SHIFT_H = 3'd2,
    ST_LATCH_H = 3'd3,
    ST_LATCH_L = 3'd4
  } sld_state_t;

  // Busy length of one transfer: two phases per bit plus two for the latch.
  function automatic int unsigned sld_busy_cycles(input int unsigned width,
                                                  input int unsigned phase);
    return (2 * width + 2) * phase;
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned sld_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sld_pace.sv
module sld_pace #(
  parameter int unsigned PHASE_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic phase_end
);
  import sld_pkg::*;

  localparam int unsigned CW = sld_cnt_w(PHASE_CLKS);
  localparam logic [CW-1:0] RELOAD = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign phase_end = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RELOAD;
    end else if (restart || phase_end) begin
      cnt_q <= RELOAD;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_PACE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RELOAD) else $error("pace counter out of range"); // R7

endmodule

// File: rtl/sld_shifter.sv
module sld_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              advance,
  output logic              msb
);
  logic [DATA_W-1:0] sr_q;

  assign msb = sr_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_val;
    end else if (advance) begin
      sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !(load && advance)) else $error("load and shift together"); // R3

endmodule

// File: rtl/sld_seq.sv
module sld_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic phase_end,
  output logic accept,
  output logic busy,
  output logic shift_adv,
  output logic sclk,
  output logic rclk
);
  import sld_pkg::*;

  localparam int unsigned BW = sld_cnt_w(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  sld_state_t st_q, st_d;
  logic [BW-1:0] bit_q;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = (st_q == ST_IDLE) && start;
  assign shift_adv = phase_end && (st_q == ST_SHIFT_H);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start) st_d = ST_SHIFT_L;
      ST_SHIFT_L: if (phase_end) st_d = ST_SHIFT_H;
      ST_SHIFT_H: if (phase_end) st_d = (bit_q == LAST_BIT) ? ST_LATCH_H : ST_SHIFT_L;
      ST_LATCH_H: if (phase_end) st_d = ST_LATCH_L;
      ST_LATCH_L: if (phase_end) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sclk  <= 1'b0;
      rclk  <= 1'b0;
    end else begin
      st_q <= st_d;
      sclk <= (st_d == ST_SHIFT_H);
      rclk <= (st_d == ST_LATCH_H);
      if (accept) bit_q <= '0;
      else if (shift_adv) bit_q <= bit_q + 1'b1;
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy) else $error("ready did not drop"); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !phase_end) |=> $stable(bit_q)) else $error("start disturbed sequence"); // R3

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PHASE_CLKS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic              drive_en,
  output logic              ready,
  output logic              ser_data,
  output logic              shift_clk,
  output logic              latch_clk,
  output logic              out_en_n
);
  import sld_pkg::*;

  localparam int unsigned BUSY_LEN = sld_busy_cycles(DATA_W, PHASE_CLKS);
  localparam int unsigned LW       = sld_cnt_w(BUSY_LEN + 1);
  localparam int unsigned EW       = sld_cnt_w(DATA_W + 1);
  localparam int unsigned PW       = sld_cnt_w(PHASE_CLKS + 1);

  // Internal events, named for the checks below.
  logic ev_accept;
  logic ev_busy;
  logic ev_phase_end;
  logic ev_shift_adv;

  sld_pace #(.PHASE_CLKS(PHASE_CLKS)) u_pace (
    .clk       (clk),
    .rst       (rst),
    .run       (ev_busy),
    .restart   (ev_accept),
    .phase_end (ev_phase_end)
  );

  sld_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase_end (ev_phase_end),
    .accept    (ev_accept),
    .busy      (ev_busy),
    .shift_adv (ev_shift_adv),
    .sclk      (shift_clk),
    .rclk      (latch_clk)
  );

  sld_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (ev_accept),
    .load_val (data_in),
    .advance  (ev_shift_adv),
    .msb      (ser_data)
  );

  assign ready = !ev_busy;

  always_ff @(posedge clk) begin
    if (rst) out_en_n <= 1'b0;
    else     out_en_n <= !drive_en;
  end

  // Observation counters for the window checks.
  logic [LW-1:0] busy_len_q;
  logic [EW-1:0] sedge_q;
  logic [PW-1:0] shi_q, lhi_q;
  logic          sclk_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_len_q <= '0;
      sedge_q    <= '0;
      shi_q      <= '0;
      lhi_q      <= '0;
      sclk_d_q   <= 1'b0;
    end else begin
      sclk_d_q   <= shift_clk;
      busy_len_q <= ready ? '0 : busy_len_q + 1'b1;
      if (ready) sedge_q <= '0;
      else if (shift_clk && !sclk_d_q) sedge_q <= sedge_q + 1'b1;
      shi_q <= shift_clk ? shi_q + 1'b1 : '0;
      lhi_q <= latch_clk ? lhi_q + 1'b1 : '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!shift_clk && !latch_clk)) else $error("strobe while idle"); // R10

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(shift_clk && latch_clk)) else $error("both strobes high"); // R10

  AST_SDO_SETUP: assert property (@(posedge clk) disable iff (rst)
    shift_clk |-> $stable(ser_data)) else $error("data moved near shift strobe"); // R6

  AST_EIGHT_EDGES: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_clk) |-> (sedge_q == EW'(DATA_W))) else $error("wrong shift count"); // R5

  AST_SHIFT_HIGH_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_clk) |-> (shi_q == PW'(PHASE_CLKS))) else $error("shift high length"); // R7

  AST_LATCH_HIGH_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_clk) |-> (lhi_q == PW'(PHASE_CLKS))) else $error("latch high length"); // R7

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (busy_len_q == LW'(BUSY_LEN))) else $error("busy length"); // R8

  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_en_n == !$past(drive_en))) else $error("enable mismatch"); // R9

endmodule

// File: tb/serial_latch_driver_bench.sv
`timescale 1ns/1ps
module serial_latch_driver_bench;
  localparam int PHASE = 5;
  localparam int W     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] data_in = '0;
  logic drive_en = 1'b1;
  logic ready, ser_data, shift_clk, latch_clk, out_en_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  serial_latch_driver #(.DATA_W(W), .PHASE_CLKS(PHASE)) u_serial_latch_driver (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in), .drive_en(drive_en),
    .ready(ready), .ser_data(ser_data), .shift_clk(shift_clk),
    .latch_clk(latch_clk), .out_en_n(out_en_n)
  );

  // Model of the external register.
  logic [W-1:0] ext_sr = '0;
  logic [W-1:0] ext_q  = '0;
  int sclk_edges = 0;
  int rclk_edges = 0;
  always @(posedge shift_clk) begin
    ext_sr <= {ext_sr[W-2:0], ser_data};
    sclk_edges <= sclk_edges + 1;
  end
  always @(posedge latch_clk) begin
    ext_q <= ext_sr;
    rclk_edges <= rclk_edges + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [W-1:0] b, input bit inject,
                      output int busy, output int se, output int re,
                      output int badph, output bit dropped);
    int s0, r0, run_s, run_r;
    logic ps, pr;
    s0 = sclk_edges; r0 = rclk_edges;
    busy = 0; badph = 0; run_s = 0; run_r = 0; ps = 0; pr = 0;
    @(negedge clk); start = 1'b1; data_in = b;
    @(negedge clk); start = 1'b0; data_in = ~b;
    dropped = !ready;
    while (!ready && busy < 1000) begin
      busy++;
      if (inject && busy == 40) begin start = 1'b1; data_in = 8'h3C; end
      else start = 1'b0;
      if (shift_clk) run_s++; else begin if (ps && run_s != PHASE) badph++; run_s = 0; end
      if (latch_clk) run_r++; else begin if (pr && run_r != PHASE) badph++; run_r = 0; end
      ps = shift_clk; pr = latch_clk;
      @(negedge clk);
    end
    start = 1'b0;
    se = sclk_edges - s0;
    re = rclk_edges - r0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busy, se, re, badph;
    bit dropped;
    int exp_busy;
    exp_busy = PHASE * 2 * (W + 1);

    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(shift_clk == 1'b0, "R1 shift_clk", shift_clk, 0);
    check(latch_clk == 1'b0, "R1 latch_clk", latch_clk, 0);
    check(out_en_n == 1'b0, "R1 out_en_n", out_en_n, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      xfer(W'(v), 1'b0, busy, se, re, badph, dropped);
      check(dropped, "R2 ready drop", !dropped, 0);
      check(ext_q == W'(v), "R4 R6 latched byte", ext_q, v);
      check(ext_sr == W'(v), "R4 shift order", ext_sr, v);
      check(se == W, "R5 shift edges", se, W);
      check(re == 1, "R5 latch pulses", re, 1);
      check(badph == 0, "R7 phase length", badph, 0);
      check(busy == exp_busy, "R8 busy length", busy, exp_busy);
      check(!shift_clk && !latch_clk, "R10 idle strobes", {shift_clk, latch_clk}, 0);
    end

    // R3: request while busy is ignored
    xfer(8'hA5, 1'b1, busy, se, re, badph, dropped);
    check(ext_q == 8'hA5, "R3 byte kept", ext_q, 8'hA5);
    check(se == W, "R3 shift edges", se, W);
    check(re == 1, "R3 latch pulses", re, 1);
    check(busy == exp_busy, "R3 busy length", busy, exp_busy);
    repeat (4) @(negedge clk);
    check(ready == 1'b1 && ext_q == 8'hA5, "R3 no follow-on transfer", ext_q, 8'hA5);

    // R9: output enable follows drive_en one clock later
    drive_en = 1'b0;
    @(negedge clk);
    check(out_en_n == 1'b1, "R9 disable", out_en_n, 1);
    drive_en = 1'b1;
    @(negedge clk);
    check(out_en_n == 1'b0, "R9 enable", out_en_n, 0);
    drive_en = 1'b0;
    xfer(8'h81, 1'b0, busy, se, re, badph, dropped);
    check(out_en_n == 1'b1, "R9 held during transfer", out_en_n, 1);
    check(ext_q == 8'h81, "R4 with outputs off", ext_q, 8'h81);

    // R1: reset mid-transfer returns to idle
    @(negedge clk); start = 1'b1; data_in = 8'hFF;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(ready && !shift_clk && !latch_clk && !out_en_n, "R1 reset mid-transfer",
          {ready, shift_clk, latch_clk, out_en_n}, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule